// File: doc/BRIEF.md
# Indexed Colour Lookup Table with Sequenced Register Loader

This block holds a 256-entry colour lookup table. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue value. A host loads the table through a 16-byte register window that takes only full 32-bit accesses. One word selects the entry to load. A second word takes colour components one at a time, always in the order red, green, blue, and each value comes from the most significant byte of the bus word. When the blue component of an entry is stored, the entry pointer moves on to the next entry by itself. The host can therefore stream a whole palette after setting the pointer once.

A separate lookup port serves the display pipeline. It takes an 8-bit pixel code and returns the 24-bit colour stored for that code one clock later. The bus read path always returns zero. Writes to word offsets 2 and 3 are dropped.

Top module: `clut_dac`

## Requirements
- R1: After reset, entries 0 to 254 read back as black (0x000000) on the lookup port and entry 255 reads back as white (0xFFFFFF). The pointer is 0 and the next component is red.
- R2: A write at word offset 0 (bus_addr = 2'd0) sets the entry pointer to bus_wdata[31:24]. It also sets the next component to red, whatever phase the loader was in.
- R3: Writes at word offset 1 (bus_addr = 2'd1) store bus_wdata[31:24] into the current entry. The first such write stores red, the second green and the third blue. Bits 23:0 of the bus word are ignored.
- R4: The write that stores blue also advances the entry pointer by one, modulo 256 (255 wraps to 0), and sets the next component back to red.
- R5: Writes at word offsets 2 and 3 change neither the table, the pointer nor the phase.
- R6: bus_rdata is zero in every cycle, whatever the access.
- R7: The lookup port has one cycle of latency. A pixel code presented before clock edge N gives its colour, as {red, green, blue} in bits 23:16, 15:8 and 7:0, after edge N.
- R8: A component written by a bus write at edge N is seen by a lookup registered at edge N+1 or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for a 32-bit access |
| bus_addr | input | 2 | Word offset within the 16-byte window |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| pix_code | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Registered colour {R,G,B} for the code |

## Verification
A table of vectors streams several consecutive entries from a single pointer write. This shows whether the automatic advance happens on blue and only on blue. A pointer write made in the middle of a triplet shows whether the phase really returns to red. Filler in the low bytes of the bus word shows whether the top byte is the one taken. Directed tests cover the reset contents at entries 0, 128 and 255, the wrap from 255 to 0, dead-offset writes that try to disturb the loader, and a lookup issued in the cycle right after a write.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int CW = 8;
  localparam int IDX_W = 8;
  localparam int ENTRIES = 1 << IDX_W;

  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_t;

  typedef enum logic [1:0] {
    OFS_PTR  = 2'd0,
    OFS_DATA = 2'd1,
    OFS_NA2  = 2'd2,
    OFS_NA3  = 2'd3
  } ofs_t;

  function automatic phase_t next_phase(input phase_t p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] bump_idx(input logic [IDX_W-1:0] i);
    return i + 1'b1;
  endfunction

  function automatic logic [CW-1:0] reset_val(input int unsigned idx);
    return (idx == ENTRIES - 1) ? {CW{1'b1}} : '0;
  endfunction
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic             wr_en,
  output logic [1:0]       wr_comp,
  output logic [IDX_W-1:0] wr_idx,
  output logic [CW-1:0]    wr_val
);
  localparam int TOP = BUS_W - 1;

  phase_t           phase_q;
  logic [IDX_W-1:0] ptr_q;
  logic             ev_ptr, ev_data, ev_blue;

  assign ev_ptr  = we && (addr == OFS_PTR);
  assign ev_data = we && (addr == OFS_DATA);
  assign ev_blue = ev_data && (phase_q == PH_BLU);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_RED;
      ptr_q   <= '0;
    end else if (ev_ptr) begin
      phase_q <= PH_RED;
      ptr_q   <= wdata[TOP -: IDX_W];
    end else if (ev_data) begin
      phase_q <= next_phase(phase_q);
      if (ev_blue) ptr_q <= bump_idx(ptr_q);
    end
  end

  assign wr_en   = ev_data;
  assign wr_comp = phase_q;
  assign wr_idx  = ptr_q;
  assign wr_val  = wdata[TOP -: CW];

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ptr |=> (ptr_q == $past(wdata[TOP -: IDX_W])) && (phase_q == PH_RED));
  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_blue |=> (ptr_q == $past(ptr_q) + 8'd1) && (phase_q == PH_RED));
  assert_dead_ofs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[1]) |=> $stable(ptr_q) && $stable(phase_q));
  assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);
  assert_green_follows_red_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data && phase_q == PH_RED) |=> phase_q == PH_GRN && $stable(ptr_q));
endmodule

// File: rtl/clut_plane.sv
module clut_plane
  import clut_pkg::*;
#(
  parameter int unsigned SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_comp,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CW-1:0]    wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CW-1:0]    rd_val
);
  logic [CW-1:0] mem_q [ENTRIES];
  logic          hit;

  assign hit = wr_en && (wr_comp == SEL[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= reset_val(i);
    end else if (hit) begin
      mem_q[wr_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_val <= '0;
    else        rd_val <= mem_q[rd_idx];
  end

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> mem_q[$past(wr_idx)] == $past(wr_val));
  assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rd_val == $past(mem_q[rd_idx]));
endmodule

// File: rtl/clut_dac.sv
module clut_dac
  import clut_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [7:0]  pix_code,
  output logic [23:0] pix_rgb
);
  localparam int NCOMP = 3;

  logic             wr_en;
  logic [1:0]       wr_comp;
  logic [IDX_W-1:0] wr_idx;
  logic [CW-1:0]    wr_val;
  logic [CW-1:0]    comp_out [NCOMP];

  clut_seq #(.BUS_W(32)) u_seq (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .wr_en(wr_en), .wr_comp(wr_comp), .wr_idx(wr_idx), .wr_val(wr_val)
  );

  for (genvar c = 0; c < NCOMP; c++) begin : g_plane
    clut_plane #(.SEL(c)) u_plane (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_comp(wr_comp),
      .wr_idx(wr_idx), .wr_val(wr_val), .rd_idx(pix_code), .rd_val(comp_out[c])
    );
  end

  assign pix_rgb   = {comp_out[0], comp_out[1], comp_out[2]};
  assign bus_rdata = '0;

  assert_rdata_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata == 32'd0);
endmodule

// File: tb/test_clut_dac.sv
`timescale 1ns/1ps
module test_clut_dac;
  logic clk = 0;
  logic rst_n = 0;
  logic bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0] pix_code = 0;
  logic [23:0] pix_rgb;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  clut_dac i_clut_dac (.*);

  // a, d, code, exp
  localparam int NV = 10;
  localparam logic [1:0]  VA [NV] = '{0, 1, 1, 1, 1, 1, 1, 1, 1, 1};
  localparam logic [31:0] VD [NV] = '{32'h1000_0000, 32'h11AB_CDEF, 32'h2200_0000,
    32'h33FF_FFFF, 32'hA1000000, 32'hB2000000, 32'hC3000000, 32'h0F000000,
    32'h1E000000, 32'h2D000000};

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic look(input logic [7:0] c, output logic [23:0] v);
    @(negedge clk); pix_code = c;
    @(negedge clk); v = pix_rgb;
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset contents
    look(8'd0, v);   chk("R1", {8'd0, v}, 32'h000000);
    look(8'd128, v); chk("R1", {8'd0, v}, 32'h000000);
    look(8'd255, v); chk("R1", {8'd0, v}, 32'hFFFFFF);
    chk("R6", bus_rdata, 0);
    // R1: pointer 0, phase red -> data write goes to entry 0 red
    wr(2'd1, 32'h5500_0000);
    look(8'd0, v); chk("R1", {8'd0, v}, 32'h550000);
    // vector table: R3/R4 stream entries 0x10,0x11
    for (int i = 0; i < NV; i++) begin
      wr(VA[i], VD[i]);
      chk("R6", bus_rdata, 0);
    end
    look(8'h10, v); chk("R3", {8'd0, v}, 32'h1122_33);
    look(8'h11, v); chk("R4", {8'd0, v}, 32'hA1B2C3);
    look(8'h12, v); chk("R4", {8'd0, v}, 32'h0F1E2D);
    // R2: pointer write mid-triplet resets phase
    wr(2'd0, 32'h2000_0000);
    wr(2'd1, 32'h7700_0000);
    wr(2'd1, 32'h8800_0000);
    wr(2'd0, 32'h2100_0000);
    wr(2'd1, 32'h9900_0000);
    look(8'h21, v); chk("R2", {8'd0, v}, 32'h990000);
    look(8'h20, v); chk("R2", {8'd0, v}, 32'h778800);
    // R5: dead offsets do nothing
    wr(2'd0, 32'h3000_0000);
    wr(2'd1, 32'h0100_0000);
    wr(2'd2, 32'hEE00_0000);
    wr(2'd3, 32'h0000_0000);
    wr(2'd1, 32'h0200_0000);
    wr(2'd1, 32'h0300_0000);
    look(8'h30, v); chk("R5", {8'd0, v}, 32'h010203);
    look(8'h31, v); chk("R5", {8'd0, v}, 32'h000000);
    // R4 wrap 255 -> 0
    wr(2'd0, 32'hFF00_0000);
    wr(2'd1, 32'h4000_0000); wr(2'd1, 32'h4100_0000); wr(2'd1, 32'h4200_0000);
    wr(2'd1, 32'h6000_0000);
    look(8'hFF, v); chk("R4", {8'd0, v}, 32'h404142);
    look(8'h00, v); chk("R4", {8'd0, v}, 32'h600000);
    // R7 / R8: lookup right after write, timing
    wr(2'd0, 32'h4000_0000);
    @(negedge clk); pix_code = 8'h40; bus_we = 1; bus_addr = 1; bus_wdata = 32'hAA00_0000;
    @(negedge clk); bus_we = 0;
    chk("R7", {8'd0, pix_rgb}, 32'h000000); // registered before write landed
    @(negedge clk);
    chk("R8", {8'd0, pix_rgb}, 32'hAA0000);
    pix_code = 8'hFF;
    chk("R7", {8'd0, pix_rgb}, 32'hAA0000); // unchanged until next edge
    @(negedge clk);
    chk("R7", {8'd0, pix_rgb}, 32'h404142);
    chk("R6", bus_rdata, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule